// File: doc/BRIEF.md
# Latched Diagnostic Status and Fault Flag

This block gathers eight diagnostic conditions from the power and tone circuits of a supply controller. It presents them as two status bytes that a host reads through a strobed data port. Three of the conditions are sticky: overload, overtemperature and power-not-good. Once one of them is seen, its bit holds at 1. It clears only when a read of the first status byte happens while the cause is gone. An active-low fault output stays asserted while any sticky bit is set.

The other bits follow their live inputs. The exception is pull-down overcurrent, which is qualified first. It reports only after its condition has lasted a programmable number of millisecond ticks, and the count restarts whenever the condition drops.

A small configuration register holds the output-voltage selection and a minimum-current monitor enable. When the enable is on, the voltage request is driven to its highest code. An undervoltage-lockout input clears every register and blocks reads and writes for as long as it is high.

Top module: `diag_status`

## Requirements
- R1: After reset with all conditions inactive, both status bytes read 0x00, the fault output is 1 and the voltage request is 0.
- R2: Status byte 1 holds overload in bit 0, overtemperature in bit 1, power-not-good in bit 2 and tone-detect in bit 3. Bits 7..4 read 0.
- R3: Status byte 2 holds voltage-monitor in bit 0, tone-monitor in bit 1, minimum-current in bit 2 and qualified pull-down overcurrent in bit 3. Bits 7..4 read 0. The first three bits and tone-detect follow their inputs in the same cycle.
- R4: A sticky bit reads 1 from the cycle after its cause is seen. It stays 1 through any read of byte 1 made while the cause is still active.
- R5: A read of byte 1 in a cycle where a sticky bit's cause is inactive clears that bit from the next cycle on. A read of byte 2 clears nothing.
- R6: The fault output is 0 while any sticky bit is 1 and returns to 1 once all three are clear.
- R7: Byte 2 bit 3 reads 1 only once the pull-down condition has stayed high through DEGLITCH_MS tick pulses. It reads 0 as soon as the condition drops, and a drop restarts the count.
- R8: While the lockout input is high, the sticky bits and the configuration register are held at 0 and read data is 0x00. Writes and reads have no effect.
- R9: A configuration write stores the voltage selection, and the voltage request equals that selection. While the stored monitor enable is 1, the request is all ones whatever the selection.
- R10: With neither read strobe high, read data is 0x00. With both high, byte 1 is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| ovl_i | input | 1 | Overload condition |
| ovt_i | input | 1 | Overtemperature condition |
| pwr_bad_i | input | 1 | Input supply below threshold |
| tone_det_i | input | 1 | Tone present on detector input |
| vmon_i | input | 1 | Output voltage out of limits |
| tmon_i | input | 1 | Tone amplitude or frequency out of limits |
| imin_i | input | 1 | Output current below minimum |
| pdn_oc_i | input | 1 | Raw pull-down stage overcurrent |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| rd_st1_i | input | 1 | Read strobe, status byte 1 |
| rd_st2_i | input | 1 | Read strobe, status byte 2 |
| rd_data_o | output | 8 | Read data |
| wr_cfg_i | input | 1 | Configuration write strobe |
| wr_vsel_i | input | VSEL_W | Voltage selection to write |
| wr_imon_en_i | input | 1 | Minimum-current monitor enable to write |
| vreq_o | output | VSEL_W | Voltage request |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The bench builds the block with DEGLITCH_MS at 4 and VSEL_W at its default of 4. A short deglitch window lets the tick pulses be counted one by one. That makes it possible to check the boundary between three and four ticks, and to show that a drop in the middle of the window restarts the count. A 4-bit selection makes the all-ones request under the monitor enable easy to tell apart from any stored code.

// File: rtl/diag_pkg.sv
package diag_pkg;
    localparam int N_STICKY = 3;
    localparam int IDX_OVL  = 0;
    localparam int IDX_OVT  = 1;
    localparam int IDX_PWR  = 2;
    localparam int BYTE_W   = 8;
    localparam int FIELD_W  = 4;
endpackage

// File: rtl/diag_sticky.sv
module diag_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         uvlo_i,
    input  logic [N-1:0] cause_i,
    input  logic         clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (cause_i[i])
                st_d.flag[i] = 1'b1;
            else if (clr_i)
                st_d.flag[i] = 1'b0;
        end
        if (uvlo_i)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R4: a set bit survives unless a clearing read meets an absent cause
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[g] && !uvlo_i && !(clr_i && !cause_i[g])) |=> flag_o[g]);
            // R5: a clearing read with the cause gone drops the bit
            a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !cause_i[g]) |=> !flag_o[g]);
        end
    endgenerate
endmodule

// File: rtl/diag_deglitch.sv
module diag_deglitch #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo_i,
    input  logic cond_i,
    input  logic tick_i,
    output logic flag_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dg_t;

    dg_t dg_d, dg_q;

    always_comb begin
        dg_d = dg_q;
        if (!cond_i || uvlo_i)
            dg_d.cnt = '0;
        else if (tick_i && dg_q.cnt != LIM)
            dg_d.cnt = dg_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dg_q <= '0;
        else        dg_q <= dg_d;
    end

    assign flag_o = cond_i && !uvlo_i && (dg_q.cnt == LIM);

    // R7: the qualified flag can only appear after the condition was already held
    a_r7_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(cond_i));
endmodule

// File: rtl/diag_cfg.sv
module diag_cfg #(
    parameter int VSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_i,
    input  logic              wr_i,
    input  logic [VSEL_W-1:0] vsel_i,
    input  logic              imon_en_i,
    output logic [VSEL_W-1:0] vreq_o
);
    typedef struct packed {
        logic [VSEL_W-1:0] vsel;
        logic              imon_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.vsel    = vsel_i;
            cfg_d.imon_en = imon_en_i;
        end
        if (uvlo_i)
            cfg_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign vreq_o = cfg_q.imon_en ? '1 : cfg_q.vsel;

    // R9: enabling the current monitor raises the request to the top code
    a_r9_imon_max: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && imon_en_i && !uvlo_i) |=> (vreq_o == '1));
endmodule

// File: rtl/diag_status.sv
module diag_status
    import diag_pkg::*;
#(
    parameter int DEGLITCH_MS = 10,
    parameter int VSEL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uvlo_i,
    input  logic              ovl_i,
    input  logic              ovt_i,
    input  logic              pwr_bad_i,
    input  logic              tone_det_i,
    input  logic              vmon_i,
    input  logic              tmon_i,
    input  logic              imin_i,
    input  logic              pdn_oc_i,
    input  logic              tick_ms_i,
    input  logic              rd_st1_i,
    input  logic              rd_st2_i,
    output logic [7:0]        rd_data_o,
    input  logic              wr_cfg_i,
    input  logic [VSEL_W-1:0] wr_vsel_i,
    input  logic              wr_imon_en_i,
    output logic [VSEL_W-1:0] vreq_o,
    output logic              fault_n_o
);
    logic [N_STICKY-1:0] cause;
    logic [N_STICKY-1:0] sticky;
    logic                pdo_flag;
    logic [FIELD_W-1:0]  field1, field2;

    always_comb begin
        cause          = '0;
        cause[IDX_OVL] = ovl_i;
        cause[IDX_OVT] = ovt_i;
        cause[IDX_PWR] = pwr_bad_i;
    end

    diag_sticky #(.N(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .uvlo_i  (uvlo_i),
        .cause_i (cause),
        .clr_i   (rd_st1_i && !uvlo_i),
        .flag_o  (sticky)
    );

    diag_deglitch #(.LIMIT(DEGLITCH_MS)) u_deglitch (
        .clk    (clk),
        .rst_n  (rst_n),
        .uvlo_i (uvlo_i),
        .cond_i (pdn_oc_i),
        .tick_i (tick_ms_i),
        .flag_o (pdo_flag)
    );

    diag_cfg #(.VSEL_W(VSEL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .uvlo_i    (uvlo_i),
        .wr_i      (wr_cfg_i),
        .vsel_i    (wr_vsel_i),
        .imon_en_i (wr_imon_en_i),
        .vreq_o    (vreq_o)
    );

    always_comb begin
        field1 = {tone_det_i, sticky[IDX_PWR], sticky[IDX_OVT], sticky[IDX_OVL]};
        field2 = {pdo_flag, imin_i, tmon_i, vmon_i};
        rd_data_o = '0;
        if (!uvlo_i) begin
            if (rd_st1_i)
                rd_data_o = {{(BYTE_W-FIELD_W){1'b0}}, field1};
            else if (rd_st2_i)
                rd_data_o = {{(BYTE_W-FIELD_W){1'b0}}, field2};
        end
    end

    assign fault_n_o = !(|sticky);

    // R6: any protection cause pulls the fault flag low on the next cycle
    a_r6_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovl_i || ovt_i || pwr_bad_i) && !uvlo_i) |=> !fault_n_o);
    // R8: lockout leaves no fault and no voltage request behind
    a_r8_uvlo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> (fault_n_o && vreq_o == '0));
    // R10: nothing is driven onto the data port without a strobe
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_st1_i && !rd_st2_i) |-> (rd_data_o == 8'h00));
endmodule

// File: tb/diag_status_tb.sv
module diag_status_tb;
    localparam int DG = 4;
    localparam int VW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 0, ovl = 0, ovt = 0, pwr = 0, tdet = 0, vmon = 0, tmon = 0, imin = 0;
    logic pdn = 0, tick = 0, rd1 = 0, rd2 = 0, wr = 0, imon_en = 0;
    logic [VW-1:0] vsel = '0;
    logic [7:0]    rdata;
    logic [VW-1:0] vreq;
    logic          fault_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    diag_status #(.DEGLITCH_MS(DG), .VSEL_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .ovl_i(ovl), .ovt_i(ovt),
        .pwr_bad_i(pwr), .tone_det_i(tdet), .vmon_i(vmon), .tmon_i(tmon),
        .imin_i(imin), .pdn_oc_i(pdn), .tick_ms_i(tick), .rd_st1_i(rd1),
        .rd_st2_i(rd2), .rd_data_o(rdata), .wr_cfg_i(wr), .wr_vsel_i(vsel),
        .wr_imon_en_i(imon_en), .vreq_o(vreq), .fault_n_o(fault_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one clock; stimulus and sampling sit 5 ns after the rising edge
    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic peek1(input string req, input logic [7:0] exp);
        rd1 = 1; #1; chk(req, rdata, exp); rd1 = 0; #1;
    endtask

    task automatic peek2(input string req, input logic [7:0] exp);
        rd2 = 1; #1; chk(req, rdata, exp); rd2 = 0; #1;
    endtask

    task automatic read1();
        rd1 = 1; cyc(); rd1 = 0;
    endtask

    task automatic pulse_tick();
        tick = 1; cyc(); tick = 0; cyc();
    endtask

    // {tone_det, vmon, tmon, imin, expected byte1, expected byte2}
    localparam logic [19:0] VEC [6] = '{
        {4'b0000, 8'h00, 8'h00},
        {4'b1000, 8'h08, 8'h00},
        {4'b0100, 8'h00, 8'h01},
        {4'b0010, 8'h00, 8'h02},
        {4'b0001, 8'h00, 8'h04},
        {4'b1111, 8'h08, 8'h07}
    };

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        peek1("R1 byte1", 8'h00);
        peek2("R1 byte2", 8'h00);
        chk("R1 fault_n", {7'd0, fault_n}, 8'h01);
        chk("R1 vreq", {4'd0, vreq}, 8'h00);
        // R10 idle port
        vmon = 1; tdet = 1; #1;
        chk("R10 idle", rdata, 8'h00);
        rd1 = 1; rd2 = 1; #1;
        chk("R10 both strobes", rdata, 8'h08);
        rd1 = 0; rd2 = 0; vmon = 0; tdet = 0;

        // R2/R3 live bit layout
        for (int i = 0; i < 6; i++) begin
            {tdet, vmon, tmon, imin} = VEC[i][19:16];
            #1;
            peek1("R2 live layout", VEC[i][15:8]);
            peek2("R3 live layout", VEC[i][7:0]);
        end
        {tdet, vmon, tmon, imin} = '0;

        // R4 sticky latch, R2 positions
        ovl = 1; cyc();
        peek1("R4 ovl set", 8'h01);
        chk("R6 fault low", {7'd0, fault_n}, 8'h00);
        read1();
        peek1("R4 held by read with cause", 8'h01);
        ovl = 0; cyc();
        peek1("R4 held without read", 8'h01);
        read1();
        peek1("R5 cleared", 8'h00);
        chk("R6 fault released", {7'd0, fault_n}, 8'h01);

        // R5 byte2 read does not clear; R2 bit positions for ovt/pwr
        ovt = 1; pwr = 1; cyc(); ovt = 0; pwr = 0; cyc();
        rd2 = 1; cyc(); rd2 = 0;
        peek1("R5 byte2 read keeps sticky", 8'h06);
        pwr = 1; read1(); pwr = 0;
        peek1("R5 only absent cause cleared", 8'h04);
        chk("R6 fault while pwr", {7'd0, fault_n}, 8'h00);
        read1();
        chk("R6 fault clear", {7'd0, fault_n}, 8'h01);

        // R7 deglitch
        pdn = 1; cyc();
        for (int i = 0; i < DG - 1; i++) pulse_tick();
        peek2("R7 below window", 8'h00);
        pulse_tick();
        peek2("R7 window reached", 8'h08);
        pdn = 0; #1;
        peek2("R7 drop clears", 8'h00);
        cyc(); pdn = 1; cyc();
        pulse_tick(); pulse_tick();
        pdn = 0; cyc(); pdn = 1; cyc();
        for (int i = 0; i < DG - 1; i++) pulse_tick();
        peek2("R7 count restarted", 8'h00);
        pulse_tick();
        peek2("R7 restarted window reached", 8'h08);
        pdn = 0; cyc();

        // R9 configuration
        vsel = 4'h5; imon_en = 0; wr = 1; cyc(); wr = 0;
        chk("R9 vsel stored", {4'd0, vreq}, 8'h05);
        vsel = 4'h3; imon_en = 1; wr = 1; cyc(); wr = 0;
        chk("R9 imon forces max", {4'd0, vreq}, 8'h0F);
        vsel = 4'h6; imon_en = 0; wr = 1; cyc(); wr = 0;

        // R8 undervoltage lockout
        ovl = 1; cyc(); ovl = 0;
        uvlo = 1; vmon = 1; cyc();
        chk("R8 fault released", {7'd0, fault_n}, 8'h01);
        chk("R8 vreq zero", {4'd0, vreq}, 8'h00);
        peek2("R8 read blocked", 8'h00);
        vsel = 4'h9; wr = 1; ovt = 1; cyc(); wr = 0; ovt = 0;
        uvlo = 0; vmon = 0; cyc();
        chk("R8 write ignored", {4'd0, vreq}, 8'h00);
        peek1("R8 nothing latched", 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule